// File: doc/BRIEF.md
# Codec Configuration and Reset Controller

This block holds the configuration state of a four-channel voice codec and turns it into the enables and mutes that the datapath and pads use. A control port delivers bytes one at a time. The first byte of each pair is an instruction, and the second is a data byte. The controller decides whether the instruction is accepted or ignored, updates its two registers, and reports the result with a one-cycle strobe.

There are two registers. The configuration register holds a software-reset bit, per-channel power-down bits and general bits. The command-enable register holds a bit that keeps the coefficient RAM powered in global power-down. While the software-reset bit is set, the register set is locked. Only an exact reset-release write and the read-all command get through. A hardware reset is requested by driving both mode pins low. That request passes through a two-flop synchroniser, and it returns every register to its default. Writing a one to the software-reset bit has the same effect.

Instruction byte: bit 7 selects read (1) or write (0), and bits 2:0 select the address. Bits 6:3 are don't-care. Address 0 is the configuration register and address 1 is the command-enable register. A read to address 7 is the read-all command. Configuration register: bit 7 is the software reset, and bits 3:0 are the power-down bits of channels 3..0. Command-enable bit 0 keeps the RAM powered.

Top module: `codec_cfg_ctrl`

## Requirements
- R1: After the asynchronous reset, the configuration register is 0x8F and the command-enable register is 0x00. At the ports this means all channels are muted, no transmit enable is set, the global power-down flag is high, the RAM is off and the pads are inputs.
- R2: When mode_i is 2'b00 for at least three clock cycles, the registers return to their R1 defaults. The values 2'b01, 2'b10 and 2'b11 cause no reset.
- R3: While configuration bit 7 is set, every instruction is ignored except two: a write of 0x0F to address 0, and a read to address 7. An ignored instruction raises ign_o and changes no register.
- R4: While bit 7 is set, a write to address 0 with any data other than 0x0F is ignored as a whole. This includes data that clears bit 7 but changes other bits. After the release write, the configuration register reads 0x0F.
- R5: While bit 7 is clear, a write to address 0 with data bit 7 set returns both registers to their R1 defaults and is acknowledged.
- R6: For each channel n, dx_oe_o[n] is 1 exactly when power-down bit n and bit 7 are both clear. vfro_mute_o[n] is the inverse of dx_oe_o[n].
- R7: all_pd_o is 1 exactly when all four power-down bits are set. coef_ram_on_o is 1 when all_pd_o is 0 or when command-enable bit 0 is 1.
- R8: pins_input_o equals configuration bit 7.
- R9: Each instruction and data pair raises exactly one of ack_o and ign_o, for one cycle. A pair raises ack_o if it is accepted and ign_o if it is not. Writes to addresses 2..7 and reads to addresses 2..6 are ignored.
- R10: An accepted read raises rd_valid_o with rd_data_o set as follows: {8'h00, register} for address 0 or 1, and {command-enable, configuration} for address 7.
- R11: The strobes, read data and all derived outputs change at the clock edge that samples the data byte. After only the instruction byte, nothing has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode pins; 2'b00 requests hardware reset |
| byte_valid_i | input | 1 | A control byte is present this cycle |
| byte_i | input | 8 | Control byte: instruction, then data |
| ack_o | output | 1 | Instruction accepted strobe |
| ign_o | output | 1 | Instruction ignored strobe |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_data_o | output | 16 | Read data |
| dx_oe_o | output | 4 | Per-channel transmit output enable |
| vfro_mute_o | output | 4 | Per-channel analog output forced to ground |
| all_pd_o | output | 1 | Global power-down flag |
| coef_ram_on_o | output | 1 | Coefficient RAM supply enable |
| pins_input_o | output | 1 | General I/O and chip-select pads held as inputs |

## Verification
The assertions assume that the control port sends bytes strictly in pairs, and that a hardware reset request does not arrive in the middle of a pair that must then be completed. The bench meets both conditions. Every byte goes through a single task that emits an instruction and a data byte back to back. The mode pins are changed only between pairs, and the bench waits long enough for the synchroniser to settle before sending the next pair. The lock-out assertion also assumes that bit 7 changes only through the defined paths. The bench reaches every one of those paths: release write, software reset, hardware reset and asynchronous reset.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int BYTE_W = 8;
  localparam int RES_BIT = 7;
  localparam logic [2:0] ADDR_CFG = 3'd0;
  localparam logic [2:0] ADDR_CMDEN = 3'd1;
  localparam logic [2:0] ADDR_ALL = 3'd7;

  typedef struct packed {
    logic       rd;
    logic [3:0] spare;
    logic [2:0] addr;
  } instr_t;

  // Configuration value loaded by any reset: soft reset set, channels powered down.
  function automatic logic [BYTE_W-1:0] cfg_default(int nch);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[RES_BIT] = 1'b1;
    for (int i = 0; i < nch; i++) v[i] = 1'b1;
    return v;
  endfunction

  // The only data byte that may release the soft reset.
  function automatic logic [BYTE_W-1:0] cfg_release(int nch);
    logic [BYTE_W-1:0] v;
    v = cfg_default(nch);
    v[RES_BIT] = 1'b0;
    return v;
  endfunction

  function automatic logic ram_powered(logic all_pd, logic retain);
    return !all_pd || retain;
  endfunction
endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic req_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], req_i};
  end

  assign req_o = chain_q[STAGES-1];
endmodule

// File: rtl/ccr_parser.sv
module ccr_parser #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          byte_valid_i,
  input  logic [BW-1:0] byte_i,
  output logic          pair_fire_o,
  output logic [BW-1:0] pair_instr_o,
  output logic [BW-1:0] pair_data_o
);
  logic          have_q;
  logic [BW-1:0] instr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      instr_q <= '0;
    end else if (flush_i) begin
      have_q  <= 1'b0;
    end else if (byte_valid_i) begin
      if (!have_q) instr_q <= byte_i;
      have_q <= !have_q;
    end
  end

  assign pair_fire_o  = byte_valid_i && have_q && !flush_i;
  assign pair_instr_o = instr_q;
  assign pair_data_o  = byte_i;
endmodule

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_i,
  input  logic              pair_fire_i,
  input  logic [BYTE_W-1:0] instr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] cmden_q,
  output logic [BYTE_W-1:0] cfg_nx,
  output logic [BYTE_W-1:0] cmden_nx,
  output logic              ack_nx,
  output logic              ign_nx,
  output logic              rd_nx,
  output logic [2*BYTE_W-1:0] rdd_nx,
  output logic              clr_ok,
  output logic              rdall_hit
);
  localparam logic [BYTE_W-1:0] CFG_DEF = cfg_default(NCH);
  localparam logic [BYTE_W-1:0] CFG_CLR = cfg_release(NCH);

  instr_t ins;
  logic   locked, accept;

  assign ins       = instr_t'(instr_i);
  assign locked    = cfg_q[RES_BIT];
  assign rdall_hit = pair_fire_i && ins.rd && (ins.addr == ADDR_ALL);
  assign clr_ok    = pair_fire_i && locked && !ins.rd &&
                     (ins.addr == ADDR_CFG) && (data_i == CFG_CLR);

  always_comb begin
    cfg_nx   = cfg_q;
    cmden_nx = cmden_q;
    accept   = 1'b0;
    rd_nx    = 1'b0;
    rdd_nx   = '0;
    if (hw_rst_i) begin
      cfg_nx   = CFG_DEF;
      cmden_nx = '0;
    end else if (pair_fire_i) begin
      if (locked) begin
        if (clr_ok) begin
          cfg_nx = data_i;
          accept = 1'b1;
        end else if (rdall_hit) begin
          accept = 1'b1;
          rd_nx  = 1'b1;
          rdd_nx = {cmden_q, cfg_q};
        end
      end else if (!ins.rd) begin
        if (ins.addr == ADDR_CFG) begin
          accept = 1'b1;
          if (data_i[RES_BIT]) begin
            cfg_nx   = CFG_DEF;
            cmden_nx = '0;
          end else begin
            cfg_nx = data_i;
          end
        end else if (ins.addr == ADDR_CMDEN) begin
          accept   = 1'b1;
          cmden_nx = data_i;
        end
      end else begin
        accept = 1'b1;
        rd_nx  = 1'b1;
        unique case (ins.addr)
          ADDR_CFG:   rdd_nx = {{BYTE_W{1'b0}}, cfg_q};
          ADDR_CMDEN: rdd_nx = {{BYTE_W{1'b0}}, cmden_q};
          ADDR_ALL:   rdd_nx = {cmden_q, cfg_q};
          default: begin
            accept = 1'b0;
            rd_nx  = 1'b0;
          end
        endcase
      end
    end
  end

  assign ack_nx = pair_fire_i && accept;
  assign ign_nx = pair_fire_i && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_DEF;
      cmden_q <= '0;
    end else begin
      cfg_q   <= cfg_nx;
      cmden_q <= cmden_nx;
    end
  end
endmodule

// File: rtl/codec_cfg_ctrl.sv
module codec_cfg_ctrl
  import ccr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                byte_valid_i,
  input  logic [BYTE_W-1:0]   byte_i,
  output logic                ack_o,
  output logic                ign_o,
  output logic                rd_valid_o,
  output logic [2*BYTE_W-1:0] rd_data_o,
  output logic [NCH-1:0]      dx_oe_o,
  output logic [NCH-1:0]      vfro_mute_o,
  output logic                all_pd_o,
  output logic                coef_ram_on_o,
  output logic                pins_input_o
);
  logic                hw_rst;
  logic                pair_fire, clr_ok, rdall_hit;
  logic [BYTE_W-1:0]   pair_instr, pair_data;
  logic [BYTE_W-1:0]   cfg_q, cmden_q, cfg_nx, cmden_nx;
  logic                ack_nx, ign_nx, rd_nx;
  logic [2*BYTE_W-1:0] rdd_nx;
  logic                res_nx, all_pd_nx;

  ccr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_i(mode_i == 2'b00), .req_o(hw_rst)
  );

  ccr_parser #(.BW(BYTE_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .flush_i(hw_rst),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .pair_fire_o(pair_fire), .pair_instr_o(pair_instr), .pair_data_o(pair_data)
  );

  ccr_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_rst_i(hw_rst), .pair_fire_i(pair_fire),
    .instr_i(pair_instr), .data_i(pair_data),
    .cfg_q(cfg_q), .cmden_q(cmden_q), .cfg_nx(cfg_nx), .cmden_nx(cmden_nx),
    .ack_nx(ack_nx), .ign_nx(ign_nx), .rd_nx(rd_nx), .rdd_nx(rdd_nx),
    .clr_ok(clr_ok), .rdall_hit(rdall_hit)
  );

  assign res_nx    = cfg_nx[RES_BIT];
  assign all_pd_nx = &cfg_nx[NCH-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dx_oe_o[ch]     <= 1'b0;
        vfro_mute_o[ch] <= 1'b1;
      end else begin
        dx_oe_o[ch]     <= !cfg_nx[ch] && !res_nx;
        vfro_mute_o[ch] <= cfg_nx[ch] || res_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o         <= 1'b0;
      ign_o         <= 1'b0;
      rd_valid_o    <= 1'b0;
      rd_data_o     <= '0;
      all_pd_o      <= 1'b1;
      coef_ram_on_o <= 1'b0;
      pins_input_o  <= 1'b1;
    end else begin
      ack_o         <= ack_nx;
      ign_o         <= ign_nx;
      rd_valid_o    <= rd_nx;
      rd_data_o     <= rd_nx ? rdd_nx : '0;
      all_pd_o      <= all_pd_nx;
      coef_ram_on_o <= ram_powered(all_pd_nx, cmden_nx[0]);
      pins_input_o  <= res_nx;
    end
  end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_rst,
  input logic              pair_fire,
  input logic              clr_ok,
  input logic              ack_o,
  input logic              ign_o,
  input logic [BYTE_W-1:0] cfg_q,
  input logic [BYTE_W-1:0] cmden_q,
  input logic [NCH-1:0]    dx_oe_o,
  input logic [NCH-1:0]    vfro_mute_o,
  input logic              all_pd_o,
  input logic              pins_input_o
);
  localparam logic [BYTE_W-1:0] CFG_DEF = cfg_default(NCH);
  localparam logic [BYTE_W-1:0] CFG_CLR = cfg_release(NCH);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && ign_o));
  p_strobe_after_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> (ack_o || ign_o));
  p_no_stray_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_fire |=> !(ack_o || ign_o));
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[RES_BIT] && pair_fire && !clr_ok && !hw_rst) |=> $stable(cfg_q) && $stable(cmden_q));
  p_release_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[RES_BIT]) |-> (cfg_q == CFG_CLR));
  p_hw_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (cfg_q == CFG_DEF) && (cmden_q == '0));
  p_enable_vs_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe_o & vfro_mute_o) == '0);
  p_global_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    all_pd_o |-> (dx_oe_o == '0) && (&vfro_mute_o));
  p_pads_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pins_input_o |-> (dx_oe_o == '0));
endmodule

bind codec_cfg_ctrl ccr_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pair_fire(pair_fire),
  .clr_ok(clr_ok), .ack_o(ack_o), .ign_o(ign_o), .cfg_q(cfg_q),
  .cmden_q(cmden_q), .dx_oe_o(dx_oe_o), .vfro_mute_o(vfro_mute_o),
  .all_pd_o(all_pd_o), .pins_input_o(pins_input_o)
);

// File: tb/codec_cfg_ctrl_test.sv
module codec_cfg_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b11;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        ack_o, ign_o, rd_valid_o;
  logic [15:0] rd_data_o;
  logic [3:0]  dx_oe_o, vfro_mute_o;
  logic        all_pd_o, coef_ram_on_o, pins_input_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_cfg, m_cmd;

  always #10 clk = ~clk;

  codec_cfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .ack_o(ack_o), .ign_o(ign_o), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .dx_oe_o(dx_oe_o), .vfro_mute_o(vfro_mute_o),
    .all_pd_o(all_pd_o), .coef_ram_on_o(coef_ram_on_o), .pins_input_o(pins_input_o)
  );

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_default();
    m_cfg = 8'h8F;
    m_cmd = 8'h00;
  endtask

  // Expected pins derived channel by channel from the model registers.
  task automatic check_pins(input string req);
    logic [3:0] e_oe, e_mute;
    logic       e_all, e_ram;
    e_all = 1'b1;
    for (int c = 0; c < 4; c++) begin
      e_oe[c]   = (m_cfg[c] == 1'b0) && (m_cfg[7] == 1'b0);
      e_mute[c] = !e_oe[c];
      if (m_cfg[c] == 1'b0) e_all = 1'b0;
    end
    e_ram = (e_all == 1'b0) || (m_cmd[0] == 1'b1);
    check(dx_oe_o == e_oe && vfro_mute_o == e_mute, {req, " R6 oe/mute"},
          {8'h0, dx_oe_o, vfro_mute_o}, {8'h0, e_oe, e_mute});
    check(all_pd_o == e_all && coef_ram_on_o == e_ram, {req, " R7 pd/ram"},
          {14'h0, all_pd_o, coef_ram_on_o}, {14'h0, e_all, e_ram});
    check(pins_input_o == m_cfg[7], {req, " R8 pads"},
          {15'h0, pins_input_o}, {15'h0, m_cfg[7]});
  endtask

  // Send an instruction/data pair; return at the negedge after the data edge.
  task automatic send(input logic [7:0] ins, input logic [7:0] dat);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i = ins;
    @(negedge clk);
    byte_i = dat;
    @(negedge clk);
    byte_valid_i = 1'b0;
  endtask

  task automatic expect_strobe(input logic acc, input string req);
    check(ack_o == acc && ign_o == !acc, {req, " R9 strobe"},
          {14'h0, ack_o, ign_o}, {14'h0, acc, !acc});
  endtask

  task automatic hw_reset(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    repeat (4) @(negedge clk);
    mode_i = 2'b11;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    model_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 reset");

    // R1/R10: read-all allowed in reset and shows defaults
    send(8'h87, 8'h00);
    expect_strobe(1'b1, "R3 read-all locked");
    check(rd_valid_o && rd_data_o == 16'h008F, "R1 R10 read-all default",
          rd_data_o, 16'h008F);

    // R3/R4: every non-release write to the configuration register is ignored
    for (int d = 0; d < 256; d++) begin
      if (d != 8'h0F) begin
        send(8'h00, 8'(d));
        expect_strobe(1'b0, "R4 locked write");
        check_pins("R3 locked");
      end
    end
    send(8'h01, 8'h01);
    expect_strobe(1'b0, "R3 cmden write locked");
    send(8'h80, 8'h00);
    expect_strobe(1'b0, "R3 single read locked");
    check(rd_valid_o == 1'b0, "R3 no read data", {15'h0, rd_valid_o}, 16'h0);
    send(8'h87, 8'h00);
    check(rd_data_o == 16'h008F, "R3 regs untouched", rd_data_o, 16'h008F);

    // R11: nothing changes after only the instruction byte
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i = 8'h00;
    @(negedge clk);
    check(!ack_o && !ign_o && pins_input_o, "R11 no early change",
          {13'h0, ack_o, ign_o, pins_input_o}, 16'h1);
    byte_i = 8'h0F;
    @(negedge clk);
    byte_valid_i = 1'b0;
    m_cfg = 8'h0F;
    expect_strobe(1'b1, "R4 release");
    check_pins("R11 R4 release");

    // R6/R7/R10: sweep every configuration value with bit 7 clear, both retain values
    for (int r = 0; r < 2; r++) begin
      send(8'h01, 8'(r));
      m_cmd = 8'(r);
      expect_strobe(1'b1, "R10 cmden write");
      for (int d = 0; d < 128; d++) begin
        send(8'h00, 8'(d));
        m_cfg = 8'(d);
        expect_strobe(1'b1, "R6 cfg write");
        check_pins("R6 R7 sweep");
        send(8'h80, 8'h00);
        check(rd_valid_o && rd_data_o == {8'h00, m_cfg}, "R10 cfg read",
              rd_data_o, {8'h00, m_cfg});
      end
      send(8'h81, 8'h00);
      check(rd_data_o == {8'h00, m_cmd}, "R10 cmden read", rd_data_o, {8'h00, m_cmd});
      send(8'h87, 8'h00);
      check(rd_data_o == {m_cmd, m_cfg}, "R10 read-all", rd_data_o, {m_cmd, m_cfg});
    end

    // R9: unused addresses ignored; don't-care bits 6:3 ignored
    for (int a = 2; a < 8; a++) begin
      send(8'(a), 8'h55);
      expect_strobe(1'b0, "R9 write unused");
      if (a != 7) begin
        send(8'h80 | 8'(a), 8'h00);
        expect_strobe(1'b0, "R9 read unused");
      end
    end
    send(8'h78, 8'h05);
    m_cfg = 8'h05;
    expect_strobe(1'b1, "R9 spare bits");
    check_pins("R9 spare bits");

    // R5: software reset from several data values
    for (int d = 0; d < 4; d++) begin
      send(8'h01, 8'h01);
      send(8'h00, 8'h00);
      m_cmd = 8'h01;
      m_cfg = 8'h00;
      send(8'h00, 8'h80 | 8'(d * 5));
      model_default();
      expect_strobe(1'b1, "R5 soft reset");
      check_pins("R5 soft reset");
      send(8'h00, 8'h0F);
      m_cfg = 8'h0F;
      send(8'h87, 8'h00);
      check(rd_data_o == 16'h000F, "R5 cmden default", rd_data_o, 16'h000F);
    end

    // R2: hardware reset only on mode 00
    send(8'h00, 8'h03);
    send(8'h01, 8'h01);
    m_cfg = 8'h03;
    m_cmd = 8'h01;
    for (int m = 1; m < 4; m++) begin
      hw_reset(2'(m));
      check_pins("R2 no reset");
    end
    hw_reset(2'b00);
    model_default();
    check_pins("R2 hw reset");
    send(8'h87, 8'h00);
    check(rd_data_o == 16'h008F, "R2 hw defaults", rd_data_o, 16'h008F);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule